// File: doc/BRIEF.md
# Bit-Banged Two-Wire Bus Port over a GPIO Byte Register

This block is a small 32-bit GPIO register that software reaches one byte at a time through an I/O window. Two output pins in it act as the data and clock lines of a two-wire SMBus/I2C bus, and each line is modelled as open-drain. The register holds three live bytes: an input byte, an output byte and a direction byte. Software runs the whole bus protocol by writing the output and direction bytes. After each such write the block senses the data line and records that level in input bit 0.

Configuration writes place the window. A write to config offset 0x40 loads a base address. A later write of 0x11 to config offset 0x44 maps the 4-byte window at base + 0x38 and drops any earlier mapping. A register write that takes effect starts a short sequence with five states. ST_IDLE goes to ST_DRV_SDA on an accepted write. ST_DRV_SDA updates the data drive and goes to ST_SNS_SDA. ST_SNS_SDA samples the data line, then goes to ST_DRV_SCL if the clock direction bit is set, or back to ST_IDLE if it is not. ST_DRV_SCL updates the clock drive and goes to ST_SNS_SCL. ST_SNS_SCL samples the data line again and returns to ST_IDLE.

Top module: `smbgp_port`

## Requirements
- R1: After reset the register is all zeros, both lines are released (`sda_pull_low`/`scl_pull_low` low, levels high with external lines high), and the window is unmapped (`io_hit` low, `io_rdata` 0xFF).
- R2: Config offset 0x40 sets the base. The window is mapped at base + 0x38 only after config offset 0x44 receives exactly 0x11, and any other value there leaves the mapping unchanged.
- R3: A new 0x11 enable moves the window to the current base + 0x38, and the old address stops hitting. A base write alone does not move a mapped window.
- R4: A read at window offset N (0..3) returns register bits [8N+7:8N], in little-endian order: byte 0 is input, byte 1 is output, byte 2 is direction. An address outside the window returns 0xFF with `io_hit` low.
- R5: A write to window offset 0 has no effect.
- R6: A write whose data equals the stored byte at that offset has no effect. The input byte is not refreshed.
- R7: A write at offset 1..3 with new data stores the byte, clears the input byte, and leaves input bit 0 equal to the sensed data-line level.
- R8: After an accepted write, the data line is driven to bit 8 when direction bit 16 is 1. It is released when bit 16 is 0.
- R9: After an accepted write, the clock line is driven to bit 9 when direction bit 17 is 1. When bit 17 is 0 the clock drive keeps its previous value.
- R10: Each line is wired-AND: level = local drive AND external drive. `*_pull_low` is high exactly when the block drives the line low.
- R11: An accepted write's sequence takes at most five clocks. Register writes that arrive while it runs are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| io_wr | input | 1 | I/O byte write strobe |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | I/O read byte (combinational) |
| io_hit | output | 1 | Address falls inside the mapped window |
| sda_ext | input | 1 | External data-line drive (0 pulls low) |
| scl_ext | input | 1 | External clock-line drive (0 pulls low) |
| sda_pull_low | output | 1 | Block pulls data line low |
| scl_pull_low | output | 1 | Block pulls clock line low |
| sda_level | output | 1 | Resolved data-line level |
| scl_level | output | 1 | Resolved clock-line level |

## Verification
The assertions assume two things about the inputs. A write strobe lasts a single cycle, and the address of a write inside the window is stable in the cycle it is sampled. The properties that forbid line changes also assume reset is applied only once, at the start. The stimulus meets these assumptions. It changes inputs only on the falling edge, keeps every write strobe to one cycle, and waits seven cycles after each write, so every sequence finishes before the next access. The one exception is a deliberate back-to-back write used to show that a write arriving mid-sequence is dropped.

// File: rtl/smbgp_pkg.sv
package smbgp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DRV_SDA = 3'd1,
        ST_SNS_SDA = 3'd2,
        ST_DRV_SCL = 3'd3,
        ST_SNS_SCL = 3'd4
    } seq_state_e;

    localparam int          REG_BYTES    = 4;
    localparam logic [7:0]  CFG_BASE_OFF = 8'h40;
    localparam logic [7:0]  CFG_EN_OFF   = 8'h44;
    localparam logic [31:0] CFG_EN_KEY   = 32'h0000_0011;
    localparam int          WIN_DISP     = 'h38;
    localparam int          BIT_SDA_OUT  = 8;
    localparam int          BIT_SCL_OUT  = 9;
    localparam int          BIT_SDA_DIR  = 16;
    localparam int          BIT_SCL_DIR  = 17;
endpackage

// File: rtl/smbgp_cfg_window.sv
module smbgp_cfg_window #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [7:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic [AW-1:0] io_addr,
    output logic          mapped,
    output logic          hit,
    output logic [1:0]    off
);
    import smbgp_pkg::*;

    logic [AW-1:0] base_q;
    logic [AW-1:0] win_q;
    logic [AW-1:0] delta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            win_q  <= '0;
            mapped <= 1'b0;
        end else if (cfg_wr) begin
            if (cfg_addr == CFG_BASE_OFF) begin
                base_q <= cfg_wdata[AW-1:0];
            end else if (cfg_addr == CFG_EN_OFF && cfg_wdata == CFG_EN_KEY) begin
                win_q  <= base_q + AW'(WIN_DISP);
                mapped <= 1'b1;
            end
        end
    end

    always_comb begin
        delta = io_addr - win_q;
        hit   = mapped && (delta < AW'(REG_BYTES));
        off   = delta[1:0];
    end
endmodule

// File: rtl/smbgp_od_line.sv
module smbgp_od_line (
    input  logic drv,
    input  logic ext,
    output logic pull_low,
    output logic level
);
    always_comb begin
        pull_low = ~drv;
        level    = drv & ext;
    end
endmodule

// File: rtl/smbgp_reg_fsm.sv
module smbgp_reg_fsm (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             off,
    input  logic [7:0]             wdata,
    input  logic                   sda_sense,
    output logic                   sda_drv,
    output logic                   scl_drv,
    output logic [31:0]            regv,
    output smbgp_pkg::seq_state_e  st
);
    import smbgp_pkg::*;

    seq_state_e st_d;
    logic       accept;

    always_comb begin
        accept = (st == ST_IDLE) && wr_en && (off != 2'd0) &&
                 (wdata != regv[8*off +: 8]);
    end

    always_comb begin
        st_d = st;
        unique case (st)
            ST_IDLE:    if (accept) st_d = ST_DRV_SDA;
            ST_DRV_SDA: st_d = ST_SNS_SDA;
            ST_SNS_SDA: st_d = regv[BIT_SCL_DIR] ? ST_DRV_SCL : ST_IDLE;
            ST_DRV_SCL: st_d = ST_SNS_SCL;
            ST_SNS_SCL: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regv    <= '0;
            sda_drv <= 1'b1;
            scl_drv <= 1'b1;
        end else begin
            unique case (st)
                ST_IDLE: if (accept) begin
                    regv[8*off +: 8] <= wdata;
                    regv[7:0]        <= 8'h00;
                end
                ST_DRV_SDA: sda_drv <= regv[BIT_SDA_DIR] ? regv[BIT_SDA_OUT] : 1'b1;
                ST_SNS_SDA: regv[0] <= regv[0] | sda_sense;
                ST_DRV_SCL: begin
                    scl_drv <= regv[BIT_SCL_OUT];
                    regv[0] <= 1'b0;
                end
                ST_SNS_SCL: regv[0] <= regv[0] | sda_sense;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smbgp_port.sv
module smbgp_port #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [7:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          io_wr,
    input  logic [AW-1:0] io_addr,
    input  logic [7:0]    io_wdata,
    output logic [7:0]    io_rdata,
    output logic          io_hit,
    input  logic          sda_ext,
    input  logic          scl_ext,
    output logic          sda_pull_low,
    output logic          scl_pull_low,
    output logic          sda_level,
    output logic          scl_level
);
    import smbgp_pkg::*;

    localparam int NLINES = 2;

    logic              mapped;
    logic [1:0]        io_off;
    logic [31:0]       reg_q;
    seq_state_e        st;
    logic [NLINES-1:0] drv, ext, pl, lvl;

    smbgp_cfg_window #(.AW(AW)) u_win (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .io_addr(io_addr), .mapped(mapped),
        .hit(io_hit), .off(io_off)
    );

    smbgp_reg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(io_wr && io_hit), .off(io_off),
        .wdata(io_wdata), .sda_sense(lvl[0]), .sda_drv(drv[0]),
        .scl_drv(drv[1]), .regv(reg_q), .st(st)
    );

    assign ext = {scl_ext, sda_ext};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        smbgp_od_line u_line (
            .drv(drv[i]), .ext(ext[i]), .pull_low(pl[i]), .level(lvl[i])
        );
    end

    assign sda_pull_low = pl[0];
    assign scl_pull_low = pl[1];
    assign sda_level    = lvl[0];
    assign scl_level    = lvl[1];
    assign io_rdata     = io_hit ? reg_q[8*io_off +: 8] : 8'hFF;
endmodule

// File: rtl/smbgp_port_chk.sv
module smbgp_port_chk (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  io_wr,
    input logic [15:0]           io_addr,
    input logic [7:0]            io_wdata,
    input logic                  io_hit,
    input logic                  mapped,
    input logic [1:0]            io_off,
    input logic [31:0]           reg_q,
    input smbgp_pkg::seq_state_e st,
    input logic                  sda_pull_low,
    input logic                  scl_pull_low,
    input logic                  sda_level
);
    import smbgp_pkg::*;

    AST_UNMAPPED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> !io_hit); // R2
    AST_OFF0_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && io_wr && io_hit && io_off == 2'd0)
        |=> (st == ST_IDLE && $stable(reg_q))); // R5
    AST_SAME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && io_wr && io_hit && io_off != 2'd0 && io_wdata == reg_q[8*io_off +: 8])
        |=> (st == ST_IDLE && $stable(reg_q))); // R6
    AST_ACT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && io_wr && io_hit && io_off != 2'd0 && io_wdata != reg_q[8*io_off +: 8])
        |=> (st == ST_DRV_SDA && reg_q[7:0] == 8'h00)); // R7
    AST_SDA_ONLY_IN_DRV: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_low) |-> $past(st) == ST_DRV_SDA); // R8
    AST_SCL_ONLY_IN_DRV: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_pull_low) |-> $past(st) == ST_DRV_SCL); // R9
    AST_PULL_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_low |-> !sda_level); // R10
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(reg_q[31:8])); // R11
endmodule

bind smbgp_port smbgp_port_chk u_chk (.*);

// File: tb/sim_smbgp_port.sv
module sim_smbgp_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_hit;
    logic        sda_ext = 1'b1;
    logic        scl_ext = 1'b1;
    logic        sda_pull_low, scl_pull_low, sda_level, scl_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    smbgp_port u0 (.*);

    typedef struct packed {
        logic [1:0]  off;
        logic [7:0]  wd;
        logic        sx;
        logic [31:0] exp;
        logic        sl;
        logic        cl;
    } vec_t;

    localparam int NV = 10;
    // R7 R8 R9 R5 R6: offset, data, external SDA drive, expected word, expected pull-lows
    localparam vec_t VEC [NV] = '{
        '{2'd2, 8'h03, 1'b1, 32'h0003_0000, 1'b1, 1'b1},
        '{2'd1, 8'h01, 1'b1, 32'h0003_0101, 1'b0, 1'b1},
        '{2'd1, 8'h03, 1'b0, 32'h0003_0300, 1'b0, 1'b0},
        '{2'd2, 8'h01, 1'b1, 32'h0001_0301, 1'b0, 1'b0},
        '{2'd1, 8'h00, 1'b1, 32'h0001_0000, 1'b1, 1'b0},
        '{2'd2, 8'h00, 1'b1, 32'h0000_0001, 1'b0, 1'b0},
        '{2'd2, 8'h00, 1'b0, 32'h0000_0001, 1'b0, 1'b0},
        '{2'd0, 8'h5A, 1'b0, 32'h0000_0001, 1'b0, 1'b0},
        '{2'd3, 8'hA5, 1'b0, 32'hA500_0000, 1'b0, 1'b0},
        '{2'd1, 8'h02, 1'b1, 32'hA500_0201, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    function automatic logic [31:0] rd_word(input logic [15:0] base);
        return 32'h0;
    endfunction

    task automatic read_word(input logic [15:0] base, output logic [31:0] w);
        for (int b = 0; b < 4; b++) begin
            io_addr = base + 16'(b);
            #1;
            w[8*b +: 8] = io_rdata;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        io_addr = 16'h1038; #1;
        check("R1 hit", {31'd0, io_hit}, 32'd0);
        check("R1 rdata", {24'd0, io_rdata}, 32'hFF);
        check("R1 lines", {28'd0, sda_pull_low, scl_pull_low, sda_level, scl_level}, 32'h3);
        // R2 wrong key does not map
        cfg(8'h40, 32'h1000);
        cfg(8'h44, 32'h10);
        io_addr = 16'h1038; #1;
        check("R2 wrong key", {31'd0, io_hit}, 32'd0);
        cfg(8'h44, 32'h11);
        io_addr = 16'h1038; #1;
        check("R2 mapped", {31'd0, io_hit}, 32'd1);
        read_word(16'h1038, w);
        check("R1 R4 zero word", w, 32'h0);
        io_addr = 16'h103C; #1;
        check("R4 past window", {23'd0, io_hit, io_rdata}, 32'h0FF);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            sda_ext = VEC[i].sx;
            wr(16'h1038 + 16'(VEC[i].off), VEC[i].wd);
            read_word(16'h1038, w);
            check($sformatf("R4 R7 R8 R9 vec%0d word", i), w, VEC[i].exp);
            check($sformatf("R8 vec%0d sda", i), {31'd0, sda_pull_low}, {31'd0, VEC[i].sl});
            check($sformatf("R9 vec%0d scl", i), {31'd0, scl_pull_low}, {31'd0, VEC[i].cl});
        end

        // R10 wired-AND: released line follows external drive
        @(negedge clk); sda_ext = 1'b0; #1;
        check("R10 ext low", {30'd0, sda_pull_low, sda_level}, 32'd0);
        @(negedge clk); sda_ext = 1'b1; #1;
        check("R10 ext high", {30'd0, sda_pull_low, sda_level}, 32'd1);

        // R11 back-to-back write is dropped
        @(negedge clk);
        io_wr = 1'b1; io_addr = 16'h1039; io_wdata = 8'h01;
        @(negedge clk);
        io_addr = 16'h103B; io_wdata = 8'h77;
        @(negedge clk);
        io_wr = 1'b0;
        repeat (7) @(negedge clk);
        read_word(16'h1038, w);
        check("R11 dropped write", w, 32'hA500_0101);

        // R3 remap
        cfg(8'h40, 32'h2000);
        io_addr = 16'h1038; #1;
        check("R3 base alone keeps window", {31'd0, io_hit}, 32'd1);
        cfg(8'h44, 32'h11);
        io_addr = 16'h1038; #1;
        check("R3 old address", {23'd0, io_hit, io_rdata}, 32'h0FF);
        read_word(16'h2038, w);
        check("R3 new window", w, 32'hA500_0101);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule